// File: doc/BRIEF.md
# Retriggerable Monostable Pulse Timer

This block is a clocked digital one-shot. It idles with its pulse output low. A rising edge on the trigger input starts a pulse that lasts a fixed number of clock cycles, set by a parameter. When that time has run out, the output drops back to low by itself. A complementary output always carries the inverse of the pulse.

A mode input selects how the timer treats a trigger that arrives while a pulse is already running. In retriggerable mode, such a trigger restarts the timing, so the output stays high while a periodic trigger stream comes faster than the pulse width. In one-shot mode, such a trigger is ignored. A sticky alarm flag rises when a pulse ends in retriggerable mode, and it stays high until reset. This lets the block watch for a missing beat in a periodic stream, such as a line-derived heartbeat that stops when power fails.

Top module: `oneshot_timer`

## Requirements
- R1: While rst_n is low, and right after it is released, pulse_o is 0, pulse_n_o is 1 and alarm_o is 0. Reset is asynchronous and active low.
- R2: A rising edge of trig_i is a cycle with trig_i high after a cycle with trig_i low. With the block idle, such an edge makes pulse_o go high from the next clock edge on. With no further edge, pulse_o then stays high for exactly PULSE_CYCLES cycles.
- R3: A trig_i that is held high counts as one edge only. It gives a single pulse of PULSE_CYCLES cycles.
- R4: When mode_retrig_i is 1 (retriggerable), an edge during a pulse restarts the timing. pulse_o then stays high until PULSE_CYCLES cycles after the latest edge.
- R5: In retriggerable mode, an edge in the last cycle of a pulse is taken as a retrigger. pulse_o shows no low cycle.
- R6: When mode_retrig_i is 0 (one-shot), edges during a pulse are ignored, and this includes an edge in its last cycle. The pulse ends PULSE_CYCLES cycles after the edge that started it, and that late edge does not start a new pulse.
- R7: In retriggerable mode, triggers with a period shorter than PULSE_CYCLES keep pulse_o constantly high.
- R8: alarm_o goes high on the same clock edge where pulse_o falls, if mode_retrig_i is 1 in the last pulse cycle. It then stays high until reset. A pulse that ends in one-shot mode leaves alarm_o low.
- R9: pulse_n_o is always the inverse of pulse_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger; its rising edge starts or restarts a pulse |
| mode_retrig_i | input | 1 | 1 = retriggerable, 0 = one-shot |
| pulse_o | output | 1 | Pulse output, high in the unstable state |
| pulse_n_o | output | 1 | Complement of pulse_o |
| alarm_o | output | 1 | Sticky missing-trigger alarm |

## Verification
A trigger edge that is driven before clock edge p shows up on pulse_o after edge p. The pulse stays high through edge p+PULSE_CYCLES-1 and falls at edge p+PULSE_CYCLES, which is also the edge where alarm_o can rise. The bench drives the inputs on the falling clock edge and samples all three outputs on that same falling edge, before it drives again. The sample taken after k rising edges is therefore compared with windows that are computed arithmetically from the trigger edge positions. The bench sweeps the spacing of a second trigger across the whole pulse and past it, in both modes. Among those spacings, one puts the edge exactly in the expiry cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    OS_ONCE   = 1'b0,
    OS_RETRIG = 1'b1
  } os_mode_e;

  function automatic int unsigned os_cnt_width(input int unsigned cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction
endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count
  import oneshot_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 5,
  localparam int unsigned CNT_W = os_cnt_width(PULSE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  os_mode_e         mode_i,
  output logic             active_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] remain_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             accept, last, upd_en;

  assign accept = rise_i & (~active_q | (mode_i == OS_RETRIG));
  assign last   = active_q & (remain_q == '0);
  assign upd_en = accept | active_q;

  always_comb begin
    active_d = active_q;
    remain_d = remain_q;
    if (accept) begin
      active_d = 1'b1;
      remain_d = LOAD;
    end else if (last) begin
      active_d = 1'b0;
    end else if (active_q) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      remain_q <= remain_d;
    end
  end

  assign active_o = active_q;
  assign expire_o = last & ~accept;
  assign remain_o = remain_q;
endmodule

// File: rtl/oneshot_alarm.sv
module oneshot_alarm
  import oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire_i,
  input  os_mode_e mode_i,
  output logic     alarm_o
);
  logic alarm_q, alarm_d, set_en;

  assign set_en  = expire_i & (mode_i == OS_RETRIG);
  assign alarm_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alarm_q <= 1'b0;
    else if (set_en) alarm_q <= alarm_d;
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 5,
  localparam int unsigned CNT_W = os_cnt_width(PULSE_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic mode_retrig_i,
  output logic pulse_o,
  output logic pulse_n_o,
  output logic alarm_o
);
  logic             trig_rise;
  logic             active;
  logic             expire;
  logic [CNT_W-1:0] remain;
  os_mode_e         mode;

  assign mode = os_mode_e'(mode_retrig_i);

  oneshot_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  oneshot_count #(.PULSE_CYCLES(PULSE_CYCLES)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (trig_rise),
    .mode_i   (mode),
    .active_o (active),
    .expire_o (expire),
    .remain_o (remain)
  );

  oneshot_alarm u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .mode_i   (mode),
    .alarm_o  (alarm_o)
  );

  assign pulse_o   = active;
  assign pulse_n_o = ~active;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned PULSE_CYCLES = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             mode_retrig,
  input logic             pulse,
  input logic             pulse_n,
  input logic             alarm,
  input logic [CNT_W-1:0] remain
);
  a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pulse, pulse_n}) == 1);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !pulse) |=> pulse);

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && mode_retrig) |=> (pulse && remain == CNT_W'(PULSE_CYCLES - 1)));

  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !mode_retrig && remain != '0) |=> (pulse && remain == $past(remain) - 1'b1));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm ##1 alarm) |-> ($past(mode_retrig) && $fell(pulse)));
endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise        (trig_rise),
  .mode_retrig (mode_retrig_i),
  .pulse       (pulse_o),
  .pulse_n     (pulse_n_o),
  .alarm       (alarm_o),
  .remain      (remain)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  localparam int W = 5;
  localparam int LEN = 2 * W + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic mode = 1'b0;
  logic pulse, pulse_n, alarm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oneshot_timer #(.PULSE_CYCLES(W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_i        (trig),
    .mode_retrig_i (mode),
    .pulse_o       (pulse),
    .pulse_n_o     (pulse_n),
    .alarm_o       (alarm)
  );

  task automatic check(input string req, input int k, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sample %0d: actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // kind 0: edges at posedge 1 and 1+g, one cycle high each
  // kind 1: held high from posedge 1 to 20 (R3)
  // kind 2: edges every 3 posedges from 1, ten of them (R7)
  function automatic logic trig_at(input int kind, input int g, input int p);
    case (kind)
      0:       return (p == 1) || (p == 1 + g);
      1:       return (p >= 1) && (p <= 20);
      default: return (p >= 1) && (p <= 28) && ((p - 1) % 3 == 0);
    endcase
  endfunction

  function automatic logic exp_pulse(input int kind, input int g, input logic rt, input int k);
    case (kind)
      0: begin
        if (g <= W) return rt ? (k >= 1 && k <= g + W) : (k >= 1 && k <= W);
        return (k >= 1 && k <= W) || (k >= 1 + g && k <= g + W);
      end
      1:       return k >= 1 && k <= W;
      default: return rt ? (k >= 1 && k <= 28 + W - 1) : ((k - 1) % 3 == 0 || k % 3 != 0) && k >= 1 && ((k - 1) % 6 < W) && k <= 28 + W - 1 && ((k - 1) % 6 < W);
    endcase
  endfunction

  function automatic int fall_at(input int kind, input int g);
    case (kind)
      0:       return (g <= W) ? g + W + 1 : W + 1;
      1:       return W + 1;
      default: return 28 + W;
    endcase
  endfunction

  function automatic string req_of(input int kind, input int g, input logic rt);
    if (kind == 1) return "R3";
    if (kind == 2) return "R7";
    if (g == W)   return rt ? "R5" : "R6";
    if (g < W)    return rt ? "R4" : "R6";
    return "R2";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trig = 1'b0;
    @(negedge clk);
    check("R1", 0, pulse, 1'b0);
    check("R1", 0, pulse_n, 1'b1);
    check("R1", 0, alarm, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int kind, input int g, input logic rt, input int len);
    string rq;
    logic ep;
    rq = req_of(kind, g, rt);
    mode = rt;
    do_reset();
    for (int k = 0; k <= len; k++) begin
      ep = exp_pulse(kind, g, rt, k);
      check(rq, k, pulse, ep);
      check("R9", k, pulse_n, ~pulse);
      check("R8", k, alarm, rt && (k >= fall_at(kind, g)));
      trig = trig_at(kind, g, k + 1);
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < 2; r++)
      for (int g = 2; g <= W + 3; g++)
        run(0, g, logic'(r), LEN);
    run(1, 0, 1'b1, 30);
    run(1, 0, 1'b0, 30);
    run(2, 0, 1'b1, 40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule